// File: doc/BRIEF.md
# FIFO Almost-Flag Offset Loader and Readback

This block holds the two threshold words that a FIFO uses to raise its almost-empty and almost-full indications, and lets them be loaded and read back over the FIFO's ordinary data buses. Loading takes place in the write clock domain. A cycle counts as an offset load when the load strobe `ld_n` and the write enable are both low. Readback takes place in the read clock domain. A cycle counts as an offset read when the load strobe and the read enable are both low, and the addressed offset word then replaces whatever was on the output bus.

The bus width can be selected as 36, 18 or 9 bits. Each threshold is 27 bits wide. It is sent as one, two or three pieces depending on the width. The write side and the read side each have their own sequence pointer, and each pointer wraps around the empty-then-full piece order. Either sequence can be paused and resumed. Only a master reset moves the pointers back to the start.

Each almost flag has a validity output. It rises two clock edges in its own domain after the last piece of its threshold has been written. Issuing an offset load and an offset read in the same cycle is not supported, and the block reports it on an error output.

Top module: `ofsreg_prog`

## Requirements
- R1: On a write-clock edge where `ld_n` or `wen_n` is high, neither threshold nor the write pointer changes.
- R2: `bus_mode` selects the bus width. Code 00 (and the spare code 11) selects 36 bits: a load takes `din[26:0]` as a whole threshold, first empty, then full, then back to empty.
- R3: Code 01 selects 18 bits: four loads, in the order empty[17:0] from `din[17:0]`, empty[26:18] from `din[8:0]`, full[17:0], full[26:18]. The fifth load wraps to empty[17:0].
- R4: Code 10 selects 9 bits: six loads, each taking `din[8:0]`, in the order empty[8:0], empty[17:9], empty[26:18], then the same three pieces of full.
- R5: A paused load sequence (`ld_n` high, or `wen_n` high) resumes with the next piece in order once both signals are low again.
- R6: While `mrst_n` is low, both pointers point at the first empty piece, both thresholds are zero, `q` is zero, and `pae_ok`, `paf_ok` and `ofs_err` are low.
- R7: A read-clock edge with `ld_n` and `ren_n` low places the piece at the read pointer onto `q`, zero-extended, in the same width-dependent order, and advances the read pointer. The read pointer wraps and moves independently of the write pointer.
- R8: A read-clock edge with `ld_n` high and `ren_n` low loads `fifo_q` into `q`. With `ren_n` high, `q` holds its value.
- R9: A read-clock edge with `prst_n` low clears `q`. It leaves both pointers and both thresholds unchanged.
- R10: `paf_ok` rises two write-clock edges after the edge that loads the last full piece. `pae_ok` rises two read-clock edges after the edge that loads the last empty piece.
- R11: `ofs_err` is high for the write-clock cycle that follows an edge at which `ld_n`, `wen_n` and `ren_n` were all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| mrst_n | input | 1 | Master reset, active low, asynchronous assert |
| prst_n | input | 1 | Partial reset, active low, synchronous to rclk |
| bus_mode | input | 2 | Bus width select: 00 = x36, 01 = x18, 10 = x9 |
| ld_n | input | 1 | Load strobe, active low |
| wen_n | input | 1 | Write enable, active low |
| ren_n | input | 1 | Read enable, active low |
| din | input | 36 | Write data bus |
| fifo_q | input | 36 | Word from the FIFO memory, for normal reads |
| q | output | 36 | Output data bus |
| pae_ok | output | 1 | Almost-empty threshold valid (rclk domain) |
| paf_ok | output | 1 | Almost-full threshold valid (wclk domain) |
| ofs_err | output | 1 | Simultaneous offset load and offset read seen |

## Verification
The bench checks that the pointer wraps after the last piece at each width. A design that mis-sized the sequence would read back the full threshold where the empty one belongs. The bench also checks that a sequence paused by either signal resumes on the right piece, and that a partial reset clears `q` without rewinding the read pointer; a design that rewound it would return the empty low piece instead of the full high piece. It checks the flag validity latency edge by edge, so a pipeline one stage short or long would show up as a flag rising one cycle early or late. Finally, it raises all three strobes at once and expects exactly one error cycle.

// File: rtl/ofsreg_pkg.sv
package ofsreg_pkg;

  typedef enum logic [1:0] {
    BW36   = 2'b00,
    BW18   = 2'b01,
    BW9    = 2'b10,
    BW_RSV = 2'b11
  } bw_e;

  // number of pieces for both thresholds together
  function automatic logic [2:0] seq_len(bw_e m);
    case (m)
      BW18:    return 3'd4;
      BW9:     return 3'd6;
      default: return 3'd2;
    endcase
  endfunction

  function automatic logic [2:0] seq_next(bw_e m, logic [2:0] p);
    return (p >= seq_len(m) - 3'd1) ? 3'd0 : p + 3'd1;
  endfunction

  function automatic logic is_full(bw_e m, logic [2:0] p);
    return p >= (seq_len(m) >> 1);
  endfunction

  function automatic logic [1:0] piece_idx(bw_e m, logic [2:0] p);
    logic [2:0] h;
    h = seq_len(m) >> 1;
    return is_full(m, p) ? 2'(p - h) : 2'(p);
  endfunction

  function automatic logic is_last(bw_e m, logic [2:0] p);
    return (p == (seq_len(m) >> 1) - 3'd1) || (p == seq_len(m) - 3'd1);
  endfunction

endpackage

// File: rtl/ofsreg_rst_sync.sv
module ofsreg_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [1:0] sh;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh <= 2'b00;
    else         sh <= {sh[0], 1'b1};
  end

  assign rst_n = sh[1];
endmodule

// File: rtl/ofsreg_wr_seq.sv
module ofsreg_wr_seq
  import ofsreg_pkg::*;
#(
  parameter int DW = 36
) (
  input  logic                clk,
  input  logic                rst_n,
  input  bw_e                 mode,
  input  logic                ld_n,
  input  logic                wen_n,
  input  logic                ren_n,
  input  logic [DW-1:0]       din,
  output logic [3*(DW/4)-1:0] ofs_e,
  output logic [3*(DW/4)-1:0] ofs_f,
  output logic                e_done,
  output logic                paf_ok,
  output logic                err
);
  localparam int QW = DW / 4;
  localparam int HW = DW / 2;
  localparam int OW = 3 * QW;

  logic [2:0]    wptr, wptr_nx;
  logic [OW-1:0] ofs_e_nx, ofs_f_nx;
  logic          e_done_nx, f_done, f_done_nx;
  logic [1:0]    fpipe;
  logic          wr_go, full_sel, last_pc, err_nx;
  logic [1:0]    pc;

  function automatic logic [OW-1:0] place(logic [OW-1:0] old, logic [DW-1:0] d,
                                          bw_e m, logic [1:0] c);
    logic [OW-1:0] r;
    r = old;
    case (m)
      BW18:    if (c == 2'd0) r[HW-1:0] = d[HW-1:0];
               else           r[OW-1:HW] = d[QW-1:0];
      BW9:     r[int'(c)*QW +: QW] = d[QW-1:0];
      default: r = d[OW-1:0];
    endcase
    return r;
  endfunction

  always_comb begin
    wr_go     = !ld_n && !wen_n;
    full_sel  = is_full(mode, wptr);
    pc        = piece_idx(mode, wptr);
    last_pc   = is_last(mode, wptr);
    wptr_nx   = wptr;
    ofs_e_nx  = ofs_e;
    ofs_f_nx  = ofs_f;
    e_done_nx = e_done;
    f_done_nx = f_done;
    if (wr_go) begin
      wptr_nx = seq_next(mode, wptr);
      if (full_sel) begin
        ofs_f_nx  = place(ofs_f, din, mode, pc);
        f_done_nx = f_done | last_pc;
      end else begin
        ofs_e_nx  = place(ofs_e, din, mode, pc);
        e_done_nx = e_done | last_pc;
      end
    end
    err_nx = wr_go && !ren_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr   <= 3'd0;
      ofs_e  <= '0;
      ofs_f  <= '0;
      e_done <= 1'b0;
      f_done <= 1'b0;
      fpipe  <= 2'b00;
      err    <= 1'b0;
    end else begin
      wptr   <= wptr_nx;
      ofs_e  <= ofs_e_nx;
      ofs_f  <= ofs_f_nx;
      e_done <= e_done_nx;
      f_done <= f_done_nx;
      fpipe  <= {fpipe[0], f_done};
      err    <= err_nx;
    end
  end

  assign paf_ok = fpipe[1];

  // R1: no load without both strobes low
  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_n || wen_n) |=> ($stable(ofs_e) && $stable(ofs_f) && $stable(wptr)));
  // R5: every accepted load moves to the next piece
  p_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_n && !wen_n) |=> (wptr != $past(wptr)));
  // R10: full validity only after the full threshold is complete
  p_paf_r10: assert property (@(posedge clk) disable iff (!rst_n)
    paf_ok |-> $past(f_done));
  // R11: error only after a simultaneous load and read
  p_err_r11: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> $past(!ld_n && !wen_n && !ren_n));
endmodule

// File: rtl/ofsreg_rd_seq.sv
module ofsreg_rd_seq
  import ofsreg_pkg::*;
#(
  parameter int DW = 36
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                prst_n,
  input  bw_e                 mode,
  input  logic                ld_n,
  input  logic                ren_n,
  input  logic [3*(DW/4)-1:0] ofs_e,
  input  logic [3*(DW/4)-1:0] ofs_f,
  input  logic [DW-1:0]       fifo_d,
  input  logic                e_done_w,
  output logic [DW-1:0]       q,
  output logic                pae_ok
);
  localparam int QW = DW / 4;
  localparam int HW = DW / 2;
  localparam int OW = 3 * QW;

  logic [2:0]    rptr, rptr_nx;
  logic [DW-1:0] q_nx;
  logic [1:0]    esync;
  logic          rd_go, fifo_go;
  logic [OW-1:0] sel_v;

  function automatic logic [DW-1:0] extract(logic [OW-1:0] v, bw_e m, logic [1:0] c);
    logic [DW-1:0] r;
    case (m)
      BW18:    r = (c == 2'd0) ? DW'(v[HW-1:0]) : DW'(v[OW-1:HW]);
      BW9:     r = DW'(v[int'(c)*QW +: QW]);
      default: r = DW'(v);
    endcase
    return r;
  endfunction

  always_comb begin
    rd_go   = !ld_n && !ren_n;
    fifo_go = ld_n && !ren_n;
    sel_v   = is_full(mode, rptr) ? ofs_f : ofs_e;
    rptr_nx = rptr;
    q_nx    = q;
    if (!prst_n) begin
      q_nx = '0;
    end else if (rd_go) begin
      q_nx    = extract(sel_v, mode, piece_idx(mode, rptr));
      rptr_nx = seq_next(mode, rptr);
    end else if (fifo_go) begin
      q_nx = fifo_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rptr  <= 3'd0;
      q     <= '0;
      esync <= 2'b00;
    end else begin
      rptr  <= rptr_nx;
      q     <= q_nx;
      esync <= {esync[0], e_done_w};
    end
  end

  assign pae_ok = esync[1];

  // R7: read pointer moves only on offset reads
  p_rptr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_n || ren_n) |=> $stable(rptr));
  // R8: output bus holds without a read
  p_qhold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ren_n && prst_n) |=> $stable(q));
  // R9: partial reset clears the bus and keeps the pointer
  p_prst_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !prst_n |=> (q == '0 && $stable(rptr)));
  // R10: empty validity only after the empty threshold is complete
  p_pae_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pae_ok |-> $past(e_done_w));
endmodule

// File: rtl/ofsreg_prog.sv
module ofsreg_prog
  import ofsreg_pkg::*;
#(
  parameter int DW = 36
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          mrst_n,
  input  logic          prst_n,
  input  logic [1:0]    bus_mode,
  input  logic          ld_n,
  input  logic          wen_n,
  input  logic          ren_n,
  input  logic [DW-1:0] din,
  input  logic [DW-1:0] fifo_q,
  output logic [DW-1:0] q,
  output logic          pae_ok,
  output logic          paf_ok,
  output logic          ofs_err
);
  localparam int OW = 3 * (DW / 4);

  logic          wrst_n, rrst_n, e_done;
  logic [OW-1:0] ofs_e, ofs_f;
  bw_e           mode;

  assign mode = bw_e'(bus_mode);

  ofsreg_rst_sync u_wrst (.clk(wclk), .arst_n(mrst_n), .rst_n(wrst_n));
  ofsreg_rst_sync u_rrst (.clk(rclk), .arst_n(mrst_n), .rst_n(rrst_n));

  ofsreg_wr_seq #(.DW(DW)) u_wr (
    .clk(wclk), .rst_n(wrst_n), .mode(mode), .ld_n(ld_n), .wen_n(wen_n),
    .ren_n(ren_n), .din(din), .ofs_e(ofs_e), .ofs_f(ofs_f), .e_done(e_done),
    .paf_ok(paf_ok), .err(ofs_err)
  );

  ofsreg_rd_seq #(.DW(DW)) u_rd (
    .clk(rclk), .rst_n(rrst_n), .prst_n(prst_n), .mode(mode), .ld_n(ld_n),
    .ren_n(ren_n), .ofs_e(ofs_e), .ofs_f(ofs_f), .fifo_d(fifo_q),
    .e_done_w(e_done), .q(q), .pae_ok(pae_ok)
  );
endmodule

// File: tb/ofsreg_prog_tb.sv
module ofsreg_prog_tb_top;
  logic        wclk = 1'b0, rclk = 1'b0;
  logic        mrst_n, prst_n, ld_n, wen_n, ren_n;
  logic [1:0]  bus_mode;
  logic [35:0] din, fifo_q, q;
  logic        pae_ok, paf_ok, ofs_err;
  int          total = 0, bad = 0;
  bit          done = 0;

  always #2 wclk = ~wclk;
  always #2 rclk = ~rclk;

  ofsreg_prog dut_i (.*);

  localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_FQ = 2'd2, OP_ID = 2'd3;
  localparam logic [1:0] M36 = 2'b00, M18 = 2'b01, M9 = 2'b10;

  typedef struct packed {
    logic [1:0]  op;
    logic [1:0]  mode;
    logic [35:0] data;
    logic [35:0] exp;
    logic [7:0]  req;
  } vec_t;

  // R2 x36, R8 hold and FIFO read, R3 x18, R4 x9, R7 wrap
  localparam vec_t TBL [29] = '{
    '{OP_WR, M36, 36'h123,     36'h0,       8'd2},
    '{OP_WR, M36, 36'h456,     36'h0,       8'd2},
    '{OP_RD, M36, 36'h0,       36'h123,     8'd2},
    '{OP_RD, M36, 36'h0,       36'h456,     8'd2},
    '{OP_ID, M36, 36'h0,       36'h456,     8'd8},
    '{OP_FQ, M36, 36'hABCDE,   36'hABCDE,   8'd8},
    '{OP_WR, M18, 36'h2AAAA,   36'h0,       8'd3},
    '{OP_WR, M18, 36'h155,     36'h0,       8'd3},
    '{OP_WR, M18, 36'h01234,   36'h0,       8'd3},
    '{OP_WR, M18, 36'h0AB,     36'h0,       8'd3},
    '{OP_RD, M18, 36'h0,       36'h2AAAA,   8'd3},
    '{OP_RD, M18, 36'h0,       36'h155,     8'd3},
    '{OP_RD, M18, 36'h0,       36'h01234,   8'd3},
    '{OP_RD, M18, 36'h0,       36'h0AB,     8'd3},
    '{OP_WR, M9,  36'h011,     36'h0,       8'd4},
    '{OP_WR, M9,  36'h022,     36'h0,       8'd4},
    '{OP_WR, M9,  36'h033,     36'h0,       8'd4},
    '{OP_WR, M9,  36'h044,     36'h0,       8'd4},
    '{OP_WR, M9,  36'h055,     36'h0,       8'd4},
    '{OP_WR, M9,  36'h066,     36'h0,       8'd4},
    '{OP_RD, M9,  36'h0,       36'h011,     8'd4},
    '{OP_RD, M9,  36'h0,       36'h022,     8'd4},
    '{OP_RD, M9,  36'h0,       36'h033,     8'd4},
    '{OP_RD, M9,  36'h0,       36'h044,     8'd4},
    '{OP_RD, M9,  36'h0,       36'h055,     8'd4},
    '{OP_RD, M9,  36'h0,       36'h066,     8'd4},
    '{OP_RD, M36, 36'h0,       36'hCC4411,  8'd4},
    '{OP_RD, M36, 36'h0,       36'h198AA44, 8'd7},
    '{OP_RD, M36, 36'h0,       36'hCC4411,  8'd7}
  };

  task automatic chk(string tag, logic [35:0] act, logic [35:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive at negedge, return at the next negedge
  task automatic cyc(logic l, logic w, logic r, logic [1:0] m, logic [35:0] d);
    ld_n = l; wen_n = w; ren_n = r; bus_mode = m; din = d; fifo_q = d;
    @(negedge wclk);
    ld_n = 1'b1; wen_n = 1'b1; ren_n = 1'b1;
  endtask

  task automatic idle();
    @(negedge wclk);
  endtask

  task automatic do_reset();
    mrst_n = 1'b0;
    repeat (2) @(negedge wclk);
  endtask

  task automatic release_rst();
    mrst_n = 1'b1;
    repeat (4) @(negedge wclk);
  endtask

  initial begin
    mrst_n = 1'b0; prst_n = 1'b1; ld_n = 1'b1; wen_n = 1'b1; ren_n = 1'b1;
    bus_mode = M36; din = '0; fifo_q = '0;
    repeat (3) @(negedge wclk);
    // R6 reset state
    chk("R6 q", q, 36'h0);
    chk("R6 pae_ok", {35'h0, pae_ok}, 36'h0);
    chk("R6 paf_ok", {35'h0, paf_ok}, 36'h0);
    chk("R6 ofs_err", {35'h0, ofs_err}, 36'h0);
    release_rst();

    foreach (TBL[i]) begin
      case (TBL[i].op)
        OP_WR: cyc(1'b0, 1'b0, 1'b1, TBL[i].mode, TBL[i].data);
        OP_RD: cyc(1'b0, 1'b1, 1'b0, TBL[i].mode, TBL[i].data);
        OP_FQ: cyc(1'b1, 1'b1, 1'b0, TBL[i].mode, TBL[i].data);
        default: cyc(1'b1, 1'b1, 1'b1, TBL[i].mode, TBL[i].data);
      endcase
      if (TBL[i].op != OP_WR)
        chk($sformatf("R%0d vec %0d", TBL[i].req, i), q, TBL[i].exp);
    end
    chk("R11 no error in normal use", {35'h0, ofs_err}, 36'h0);
    chk("R10 pae_ok after loads", {35'h0, pae_ok}, 36'h1);
    chk("R10 paf_ok after loads", {35'h0, paf_ok}, 36'h1);

    // R6 master reset clears flags and bus
    do_reset();
    chk("R6 q after mrst", q, 36'h0);
    chk("R6 pae_ok after mrst", {35'h0, pae_ok}, 36'h0);
    chk("R6 paf_ok after mrst", {35'h0, paf_ok}, 36'h0);
    release_rst();

    // R10 validity latency, x36
    cyc(1'b0, 1'b0, 1'b1, M36, 36'h5A5);
    chk("R10 pae 0 edge0", {35'h0, pae_ok}, 36'h0);
    idle();
    chk("R10 pae 0 edge1", {35'h0, pae_ok}, 36'h0);
    idle();
    chk("R10 pae 1 edge2", {35'h0, pae_ok}, 36'h1);
    chk("R10 paf still 0", {35'h0, paf_ok}, 36'h0);
    cyc(1'b0, 1'b0, 1'b1, M36, 36'h4C0000);
    chk("R10 paf 0 edge0", {35'h0, paf_ok}, 36'h0);
    idle();
    chk("R10 paf 0 edge1", {35'h0, paf_ok}, 36'h0);
    idle();
    chk("R10 paf 1 edge2", {35'h0, paf_ok}, 36'h1);

    // R5 / R1 interrupted x18 load
    cyc(1'b0, 1'b0, 1'b1, M18, 36'h00011);
    cyc(1'b1, 1'b0, 1'b1, M18, 36'h3FFFF);
    cyc(1'b0, 1'b1, 1'b1, M18, 36'h3FFFF);
    cyc(1'b0, 1'b0, 1'b1, M18, 36'h077);
    cyc(1'b0, 1'b1, 1'b0, M18, 36'h0);
    chk("R1 empty low untouched by paused cycles", q, 36'h11);
    cyc(1'b0, 1'b1, 1'b0, M18, 36'h0);
    chk("R5 resumed with empty high", q, 36'h077);
    cyc(1'b0, 1'b0, 1'b1, M18, 36'h00222);
    cyc(1'b0, 1'b1, 1'b0, M18, 36'h0);
    chk("R5 next piece full low", q, 36'h222);

    // R9 partial reset
    prst_n = 1'b0;
    idle();
    prst_n = 1'b1;
    chk("R9 q cleared", q, 36'h0);
    cyc(1'b0, 1'b1, 1'b0, M18, 36'h0);
    chk("R9 read pointer kept (full high)", q, 36'h13);
    cyc(1'b0, 1'b1, 1'b0, M18, 36'h0);
    chk("R7 read wraps to empty low", q, 36'h11);

    // R11 collision
    cyc(1'b0, 1'b0, 1'b0, M36, 36'h0);
    chk("R11 err raised", {35'h0, ofs_err}, 36'h1);
    idle();
    chk("R11 err one cycle", {35'h0, ofs_err}, 36'h0);

    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge wclk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule